// File: doc/BRIEF.md
# Filtered Undervoltage Reset Generator

This block drives the active-low reset line of a microcontroller that is powered from an on-chip regulator. A comparator reports when the regulator output is below its monitoring threshold. That raw report is synchronised into the block clock. It is believed only after it has stayed asserted for a programmable persistence window. Short dips caused by load steps or noise therefore leave the microcontroller running. The mode controller can also demand a low reset line directly. It does this in the power states where the regulator is off or the die is too hot.

Once every reason to hold reset has gone, the line stays low for a programmable extension time before it is released. A fresh reason that appears during the extension starts the extension again from zero. At the moment of release the block emits a single-cycle completion strobe, which the mode controller uses to sample its own enable input and pick the next operating state. The filtered undervoltage flag is also exported, so the controller can react to a valid undervoltage.

Top module: `uvr_reset_gen`

## Requirements
- R1: While `rst_n` is low, `rst_pin_n_o` is 0, `uv_flt_o` is 0 and `rel_done_o` is 0.
- R2: `uv_raw_i` (1 = regulator below threshold) passes through `SYNC_STAGES` flops. `uv_flt_o` rises after the edge at which the synchronised flag has been 1 for `FILT_CYC` consecutive edges. With the defaults used by the bench, the flag is first seen high `SYNC_STAGES + FILT_CYC` edges after the first edge that samples the raw flag high.
- R3: A raw undervoltage lasting fewer than `FILT_CYC` cycles has no effect: `uv_flt_o` stays 0, `rst_pin_n_o` stays 1 and no `rel_done_o` strobe appears.
- R4: `uv_flt_o` falls at the first edge that sees the synchronised flag at 0, and the persistence count clears there. Two sub-window dips separated by one clear cycle never produce the flag.
- R5: `rst_pin_n_o` is driven to 0 at the edge after `uv_flt_o` or `force_low_i` is 1, and stays 0 while either is 1.
- R6: `rst_pin_n_o` returns to 1 only after `EXT_CYC` consecutive edges with neither `uv_flt_o` nor `force_low_i` set. For a raw dip of L ≥ `FILT_CYC` cycles, the line is low for L − `FILT_CYC` + `EXT_CYC` cycles.
- R7: A hold reason that appears during the extension restarts it. The release then comes `EXT_CYC` edges after the last hold is removed.
- R8: `rel_done_o` is high for exactly one cycle per release, in the cycle in which `rst_pin_n_o` first reads 1.
- R9: After `rst_n` is released with no hold reason present, a power-up extension keeps `rst_pin_n_o` at 0 for `EXT_CYC` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block logic |
| uv_raw_i | input | 1 | Unfiltered, asynchronous comparator flag; 1 = regulator output below threshold |
| force_low_i | input | 1 | Synchronous request from the mode controller to hold reset low |
| rst_pin_n_o | output | 1 | Level for the microcontroller reset pin; 0 = reset asserted |
| uv_flt_o | output | 1 | Undervoltage flag after synchronisation and persistence filtering |
| rel_done_o | output | 1 | Single-cycle strobe marking the release of reset |

## Verification
A persistence counter that fails to clear, or that saturates at the wrong value, shows at the ports in the length of `uv_flt_o` and in the count of low cycles on the reset line. A dip one cycle short of the window would then wrongly pull reset low, or a valid one would be missed, within `FILT_CYC` + `SYNC_STAGES` + 1 cycles. An extension counter that loses its restart or is off by one moves the rising edge of `rst_pin_n_o` and the strobe by that amount. The sweeps therefore count low cycles exactly rather than just watching for a release. A strobe that is duplicated or misaligned with the rising edge is visible in the same cycle.

// File: rtl/uvr_pkg.sv
package uvr_pkg;

   // Phase of the reset-extension sequencer
   typedef enum logic [1:0] {
      EXT_HOLD  = 2'd0,
      EXT_COUNT = 2'd1,
      EXT_REL   = 2'd2
   } ext_phase_t;

endpackage

// File: rtl/uvr_sync.sv
module uvr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("uvr_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else if (STAGES == 1) begin : g_single
         logic ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= 1'b0;
            else        ff <= d_i;
         end
         assign q_o = ff;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_i};
         end
         assign q_o = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uvr_filter.sv
module uvr_filter #(
   parameter int FILT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uv_s_i,
   output logic flt_o
);

   localparam int FW = (FILT_CYC > 1) ? $clog2(FILT_CYC + 1) : 1;

   logic flt_q;

   generate
      if (FILT_CYC < 1) begin : g_bad
         $error("uvr_filter: FILT_CYC must be at least 1");
      end

      if (FILT_CYC == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flt_q <= 1'b0;
            else        flt_q <= uv_s_i;
         end
      end else begin : g_count
         logic [FW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               flt_q <= 1'b0;
            end else if (!uv_s_i) begin
               run_q <= '0;
               flt_q <= 1'b0;
            end else if (run_q == FW'(FILT_CYC - 1)) begin
               flt_q <= 1'b1;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   assign flt_o = flt_q;

   // R2: flag can only appear after the synchronised level was present
   a_r2_flag_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_q) |-> $past(uv_s_i));

   // R4: a clear synchronised level removes the flag on the next edge
   a_r4_flag_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !uv_s_i |=> !flt_q);

endmodule

// File: rtl/uvr_extend.sv
module uvr_extend
   import uvr_pkg::*;
#(
   parameter int EXT_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   output logic rel_n_o,
   output logic done_o
);

   localparam int EW = (EXT_CYC > 1) ? $clog2(EXT_CYC + 1) : 1;
   localparam logic [EW-1:0] LAST = EW'(EXT_CYC - 1);

   ext_phase_t    phase_q;
   logic [EW-1:0] cnt_q;
   logic          done_q;

   generate
      if (EXT_CYC < 1) begin : g_bad
         $error("uvr_extend: EXT_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= EXT_HOLD;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (hold_i) begin
            phase_q <= EXT_HOLD;
            cnt_q   <= '0;
         end else if (phase_q != EXT_REL) begin
            if (cnt_q == LAST) begin
               phase_q <= EXT_REL;
               done_q  <= 1'b1;
            end else begin
               phase_q <= EXT_COUNT;
               cnt_q   <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign rel_n_o = (phase_q == EXT_REL);
   assign done_o  = done_q;

   // R5: any hold reason forces the line low on the next edge
   a_r5_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> !rel_n_o);

   // R6: release never follows a cycle with a hold reason present
   a_r6_release_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rel_n_o) |-> !$past(hold_i));

   // R8: strobe coincides with the rising edge of the line
   a_r8_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $rose(rel_n_o));

   // R8: strobe lasts one cycle only
   a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/uvr_reset_gen.sv
module uvr_reset_gen #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 1250,
   parameter int EXT_CYC     = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uv_raw_i,
   input  logic force_low_i,
   output logic rst_pin_n_o,
   output logic uv_flt_o,
   output logic rel_done_o
);

   logic uv_s;
   logic uv_flt;
   logic hold;

   uvr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (uv_raw_i),
      .q_o   (uv_s)
   );

   uvr_filter #(.FILT_CYC(FILT_CYC)) u_filter (
      .clk    (clk),
      .rst_n  (rst_n),
      .uv_s_i (uv_s),
      .flt_o  (uv_flt)
   );

   assign hold = uv_flt | force_low_i;

   uvr_extend #(.EXT_CYC(EXT_CYC)) u_extend (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold_i  (hold),
      .rel_n_o (rst_pin_n_o),
      .done_o  (rel_done_o)
   );

   assign uv_flt_o = uv_flt;

   // R5: a filtered undervoltage is always mirrored by a low line next cycle
   a_r5_flag_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
      uv_flt_o |=> !rst_pin_n_o);

endmodule

// File: tb/uvr_reset_gen_test.sv
`timescale 1ns/1ps
module uvr_reset_gen_test;

   localparam int SYNC = 2;
   localparam int FILT = 4;
   localparam int EXT  = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic uv_raw = 1'b0;
   logic force_low = 1'b0;
   logic rst_pin_n, uv_flt, rel_done;

   int total = 0;
   int fails = 0;

   // window statistics
   int n_step, n_flt, n_low, n_done, n_aligned, first_flt, first_low;
   logic prev_pin;

   always #10 clk = ~clk;

   uvr_reset_gen #(.SYNC_STAGES(SYNC), .FILT_CYC(FILT), .EXT_CYC(EXT)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .uv_raw_i    (uv_raw),
      .force_low_i (force_low),
      .rst_pin_n_o (rst_pin_n),
      .uv_flt_o    (uv_flt),
      .rel_done_o  (rel_done)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_stats();
      n_step = 0; n_flt = 0; n_low = 0; n_done = 0; n_aligned = 0;
      first_flt = -1; first_low = -1; prev_pin = rst_pin_n;
   endtask

   // sample outputs at the falling edge, then apply the next inputs
   task automatic step(input logic uv, input logic frc);
      @(negedge clk);
      n_step++;
      if (uv_flt) begin
         n_flt++;
         if (first_flt < 0) first_flt = n_step;
      end
      if (!rst_pin_n) begin
         n_low++;
         if (first_low < 0) first_low = n_step;
      end
      if (rel_done) begin
         n_done++;
         if (rst_pin_n && !prev_pin) n_aligned++;
      end
      prev_pin = rst_pin_n;
      uv_raw = uv;
      force_low = frc;
   endtask

   task automatic settle();
      for (int i = 0; i < EXT + FILT + SYNC + 8; i++) step(1'b0, 1'b0);
      clear_stats();
   endtask

   initial begin
      #(200000 * 20);
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      // R1: outputs during reset
      repeat (3) @(negedge clk);
      check("R1 pin", int'(rst_pin_n), 0);
      check("R1 flag", int'(uv_flt), 0);
      check("R1 strobe", int'(rel_done), 0);

      // R9: power-up extension
      clear_stats();
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < EXT + 5; i++) step(1'b0, 1'b0);
      check("R9 power-up low cycles", n_low, EXT - 1);
      check("R8 power-up strobes", n_done, 1);
      check("R8 power-up strobe on rise", n_aligned, 1);

      // R2 R3 R6 R8: sweep raw dip length
      for (int len = 1; len <= FILT + 3; len++) begin
         settle();
         for (int i = 0; i < len; i++) step(1'b1, 1'b0);
         for (int i = 0; i < EXT + FILT + SYNC + 8; i++) step(1'b0, 1'b0);
         if (len < FILT) begin
            check($sformatf("R3 flag len=%0d", len), n_flt, 0);
            check($sformatf("R3 pin low len=%0d", len), n_low, 0);
            check($sformatf("R3 strobe len=%0d", len), n_done, 0);
         end else begin
            check($sformatf("R4 flag width len=%0d", len), n_flt, len - FILT + 1);
            check($sformatf("R2 flag latency len=%0d", len), first_flt, SYNC + FILT + 1);
            check($sformatf("R5 pin fall len=%0d", len), first_low, SYNC + FILT + 2);
            check($sformatf("R6 pin low len=%0d", len), n_low, len - FILT + EXT);
            check($sformatf("R8 strobe len=%0d", len), n_done, 1);
            check($sformatf("R8 aligned len=%0d", len), n_aligned, 1);
         end
      end

      // R4: two short dips split by one clear cycle
      settle();
      for (int i = 0; i < FILT - 1; i++) step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      for (int i = 0; i < FILT - 1; i++) step(1'b1, 1'b0);
      for (int i = 0; i < EXT + 8; i++) step(1'b0, 1'b0);
      check("R4 split dips flag", n_flt, 0);
      check("R4 split dips pin low", n_low, 0);

      // R5 R6: sweep force length
      for (int f = 1; f <= 5; f++) begin
         settle();
         for (int i = 0; i < f; i++) step(1'b0, 1'b1);
         for (int i = 0; i < EXT + 8; i++) step(1'b0, 1'b0);
         check($sformatf("R5 force fall f=%0d", f), first_low, 2);
         check($sformatf("R6 force low f=%0d", f), n_low, f + EXT - 1);
         check($sformatf("R5 force flag f=%0d", f), n_flt, 0);
         check($sformatf("R8 force strobe f=%0d", f), n_done, 1);
      end

      // R7: hold reappears during extension
      settle();
      step(1'b0, 1'b1);
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      for (int i = 0; i < EXT + 8; i++) step(1'b0, 1'b0);
      check("R7 restart low cycles", n_low, EXT + 5);
      check("R7 restart strobes", n_done, 1);

      // R3: short dip during extension does not restart it
      settle();
      step(1'b0, 1'b1);
      for (int i = 0; i < FILT - 1; i++) step(1'b1, 1'b0);
      for (int i = 0; i < EXT + 8; i++) step(1'b0, 1'b0);
      check("R3 dip in extension low cycles", n_low, EXT);
      check("R3 dip in extension flag", n_flt, 0);

      // R1: reset asserted mid-operation
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 pin after reassert", int'(rst_pin_n), 0);
      check("R1 strobe after reassert", int'(rel_done), 0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule